// File: doc/BRIEF.md
# Two-Dimensional Word Memory Unit

This block is a word-addressed random access store of 16-bit words. A requester writes an address into the address holding register and, for a write, a data word into the data holding register. It then raises either a read request or a write request. A read copies the addressed word into the data holding register. A write copies the data holding register into the addressed word.

The 12-bit address is cut into two 6-bit fields. The upper field selects one of 64 rows and the lower field selects one of 64 columns. Each field feeds its own 6-to-64 one-hot decoder. Only the word where the live row line and the live column line meet is read or written. Every word is reached in the same number of cycles, whatever its address.

A synchronous reset clears both holding registers and the completion flag. It leaves the stored words untouched.

Top module: `word_mem2d`

## Requirements
- R1: With `rst` high at a clock edge, `mar_out`, `mdr_out` and `done` read zero after that edge, and words written before the reset can still be read back afterwards.
- R2: With no request high, `addr_load` copies `addr_in` into the address register and `data_load` copies `data_in` into the data register at the next edge; both are visible on `mar_out` and `mdr_out`.
- R3: A write request sampled at an edge stores the data register into the word at the current address on that edge, and leaves `mdr_out` unchanged.
- R4: A read request (with no write request) sampled at an edge places the word at the current address on `mdr_out` after that edge. The value holds until the next read or data load.
- R5: `done` is high for exactly the one cycle after each edge at which a request was sampled, and low in every other cycle.
- R6: Address bits [11:6] pick the row and bits [5:0] pick the column. Each decoder raises only line k for input value k. A write changes only the one word at that row and column; words that share just its row or just its column keep their values.
- R7: Every address from 0 to 4095 can be written and read, including the corner addresses 0x000, 0x03F, 0xFC0 and 0xFFF.
- R8: While either request is high, `addr_load` and `data_load` are ignored: the address register keeps its value, and the data register takes only the read result, if any.
- R9: If both requests are high together, the write is performed and the read is ignored, so `mdr_out` keeps the written value rather than the word's old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 12 | Address to load into the address register |
| addr_load | input | 1 | Load strobe for the address register |
| data_in | input | 16 | Word to load into the data register |
| data_load | input | 1 | Load strobe for the data register |
| fetch_req | input | 1 | Read request |
| store_req | input | 1 | Write request |
| mar_out | output | 12 | Current address register |
| mdr_out | output | 16 | Current data register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench writes to the four corner words and to two adjacent words that share a row. If the row and column fields were swapped or misdecoded, one of these writes would overwrite another or be read back from the wrong place. It rewrites one word and then reads its row neighbour, which catches a selection that enables a whole row or a whole column. It raises loads together with a request, which exposes a design that lets a late load corrupt a pending access. It raises both requests at once, where a design that gave the read priority would return the word's old value. It resets between a write and a read-back, which catches a reset that clears the array or leaves stale holding registers.

// File: rtl/word_mem2d_pkg.sv
package word_mem2d_pkg;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_WORD_W = 16;
endpackage

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
    parameter int SEL_W = 6,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cell_grid.sv
module cell_grid #(
    parameter int ROW_W  = 6,
    parameter int COL_W  = 6,
    parameter int WORD_W = 16,
    localparam int ROWS = 1 << ROW_W,
    localparam int COLS = 1 << COL_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROWS-1:0]   row_sel,
    input  logic [COLS-1:0]   col_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] cells    [ROWS][COLS];
    logic [WORD_W-1:0] col_pick [COLS];

    // a word is written only where its row line and column line are both live
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en && row_sel[r] && col_sel[c]) begin
                    cells[r][c] <= wr_data;
                end
            end
        end
    end

    // first narrow each column to the live row, then pick the live column
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            col_pick[c] = '0;
            for (int r = 0; r < ROWS; r++) begin
                if (row_sel[r]) begin
                    col_pick[c] = col_pick[c] | cells[r][c];
                end
            end
        end
        rd_data = '0;
        for (int c = 0; c < COLS; c++) begin
            if (col_sel[c]) begin
                rd_data = rd_data | col_pick[c];
            end
        end
    end
endmodule

// File: rtl/word_mem2d.sv
module word_mem2d
    import word_mem2d_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W,
    localparam int ROW_W = ADDR_W / 2,
    localparam int COL_W = ADDR_W - ROW_W,
    localparam int ROWS  = 1 << ROW_W,
    localparam int COLS  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_load,
    input  logic [WORD_W-1:0] data_in,
    input  logic              data_load,
    input  logic              fetch_req,
    input  logic              store_req,
    output logic [ADDR_W-1:0] mar_out,
    output logic [WORD_W-1:0] mdr_out,
    output logic              done
);
    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [ROWS-1:0]   row_lines;
    logic [COLS-1:0]   col_lines;
    logic [WORD_W-1:0] rd_word;
    logic              wr_en;

    onehot_decoder #(.SEL_W(ROW_W)) u_row_dec (
        .sel   (regs_q.mar[ADDR_W-1:COL_W]),
        .lines (row_lines)
    );

    onehot_decoder #(.SEL_W(COL_W)) u_col_dec (
        .sel   (regs_q.mar[COL_W-1:0]),
        .lines (col_lines)
    );

    assign wr_en = store_req && !rst;

    cell_grid #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_grid (
        .clk     (clk),
        .wr_en   (wr_en),
        .row_sel (row_lines),
        .col_sel (col_lines),
        .wr_data (regs_q.mdr),
        .rd_data (rd_word)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        if (store_req) begin
            regs_d.done = 1'b1;
        end else if (fetch_req) begin
            regs_d.mdr  = rd_word;
            regs_d.done = 1'b1;
        end else begin
            if (addr_load) regs_d.mar = addr_in;
            if (data_load) regs_d.mdr = data_in;
        end
        if (rst) regs_d = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign mar_out = regs_q.mar;
    assign mdr_out = regs_q.mdr;
    assign done    = regs_q.done;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (mar_out == '0 && mdr_out == '0 && !done));

    // R6
    row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(row_lines) == 1);

    // R6
    col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(col_lines) == 1);

    // R4
    fetch_result_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !store_req) |=> mdr_out == $past(rd_word));

    // R3
    store_keeps_mdr_chk: assert property (@(posedge clk) disable iff (rst)
        store_req |=> $stable(mdr_out));

    // R5
    done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req || store_req) |=> done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req || store_req) |=> !done);

    // R8
    mar_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req || store_req) |=> $stable(mar_out));
endmodule

// File: tb/word_mem2d_tb.sv
module word_mem2d_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    // {is_store, address, data (write value or expected read value)}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 12'h000, 16'hA5A5},
        {1'b1, 12'hFFF, 16'h5A5A},
        {1'b1, 12'h03F, 16'h1234},
        {1'b1, 12'hFC0, 16'h4321},
        {1'b1, 12'h041, 16'hBEEF},
        {1'b1, 12'h040, 16'h0F0F},
        {1'b0, 12'h000, 16'hA5A5},
        {1'b0, 12'hFFF, 16'h5A5A},
        {1'b0, 12'h03F, 16'h1234},
        {1'b0, 12'hFC0, 16'h4321},
        {1'b0, 12'h041, 16'hBEEF},
        {1'b0, 12'h040, 16'h0F0F},
        {1'b1, 12'h041, 16'hC0DE},
        {1'b0, 12'h041, 16'hC0DE},
        {1'b0, 12'h040, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr_in = '0;
    logic        addr_load = 1'b0;
    logic [15:0] data_in = '0;
    logic        data_load = 1'b0;
    logic        fetch_req = 1'b0;
    logic        store_req = 1'b0;
    logic [11:0] mar_out;
    logic [15:0] mdr_out;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_mem2d u_dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .addr_load(addr_load),
        .data_in(data_in), .data_load(data_load), .fetch_req(fetch_req),
        .store_req(store_req), .mar_out(mar_out), .mdr_out(mdr_out), .done(done)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_regs(input logic [11:0] a, input logic [15:0] d);
        addr_in = a; addr_load = 1'b1; data_in = d; data_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; data_load = 1'b0;
    endtask

    task automatic do_store(input logic [11:0] a, input logic [15:0] d);
        load_regs(a, d);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        check(done == 1'b1, "R5 store done", 32'(done), 32'd1);
        check(mdr_out == d, "R3 mdr kept", 32'(mdr_out), 32'(d));
    endtask

    task automatic do_fetch(input logic [11:0] a, input logic [15:0] exp, input string tag);
        addr_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        check(done == 1'b1, "R5 fetch done", 32'(done), 32'd1);
        check(mdr_out == exp, tag, 32'(mdr_out), 32'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(mar_out == '0 && mdr_out == '0 && done == 1'b0, "R1 reset state",
              {4'd0, mar_out, mdr_out}, 32'd0);
        rst = 1'b0;

        // R2 loads
        load_regs(12'h5A3, 16'h7E57);
        check(mar_out == 12'h5A3, "R2 mar load", 32'(mar_out), 32'h5A3);
        check(mdr_out == 16'h7E57, "R2 mdr load", 32'(mdr_out), 32'h7E57);
        check(done == 1'b0, "R5 idle done low", 32'(done), 32'd0);

        // R3 R4 R6 R7 vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][28]) do_store(VEC[i][27:16], VEC[i][15:0]);
            else do_fetch(VEC[i][27:16], VEC[i][15:0], "R4 R6 R7 table read");
        end

        // R5 done is a single-cycle pulse
        @(negedge clk);
        check(done == 1'b0, "R5 done falls", 32'(done), 32'd0);

        // R8 loads ignored while a fetch is pending (MAR holds 0x040)
        addr_in = 12'h123; addr_load = 1'b1; data_in = 16'hDEAD; data_load = 1'b1;
        fetch_req = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; data_load = 1'b0; fetch_req = 1'b0;
        check(mar_out == 12'h040, "R8 mar frozen", 32'(mar_out), 32'h040);
        check(mdr_out == 16'h0F0F, "R8 mdr read not load", 32'(mdr_out), 32'h0F0F);

        // R9 both requests: write wins
        do_store(12'h7C2, 16'h1111);
        data_in = 16'h2222; data_load = 1'b1;
        @(negedge clk);
        data_load = 1'b0;
        fetch_req = 1'b1; store_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0; store_req = 1'b0;
        check(mdr_out == 16'h2222, "R9 write wins mdr", 32'(mdr_out), 32'h2222);
        do_fetch(12'h7C2, 16'h2222, "R9 write stored");

        // R1 reset keeps array contents
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(mar_out == '0 && mdr_out == '0 && done == 1'b0, "R1 reset clears regs",
              {4'd0, mar_out, mdr_out}, 32'd0);
        do_fetch(12'hFFF, 16'h5A5A, "R1 cells kept");
        do_fetch(12'h7C2, 16'h2222, "R1 cells kept 2");

        // R6 column neighbour of rewritten word untouched
        do_fetch(12'h001, 16'h0000, "R6 column neighbour");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule